// File: doc/BRIEF.md
# Program-Memory Table Transfer Unit

This unit moves single bytes between a word-wide program memory and an 8-bit table latch on behalf of the processor core. It owns a 21-bit byte pointer covering the whole program space and, on each accepted table request, forms a byte address from that pointer under one of four stepping modes. The stepping modes are: hold, step up after use, step down after use, and step up before use. It also updates the pointer as the mode says. The core's own register-write path can load the pointer and the latch directly.

The unit owns the program address bus. While it is idle, the bus carries the program counter. During the single transfer cycle of a table operation it carries the word part of the table address instead. Because memory words are 16 bits wide, bit 0 of the table address picks the byte lane and bits 20:1 form the word address.

A read captures the selected lane into the latch. A write drives the latch onto the shared data bus, which is otherwise released, and raises a one-hot lane strobe.

Control is a three-state machine:
- `ST_IDLE` is the resting state.
- `ST_RD_XFER` is the read transfer cycle.
- `ST_WR_XFER` is the write transfer cycle.

Its transitions are:
- *take-read* goes from `ST_IDLE` to `ST_RD_XFER` on a request with the read function.
- *take-write* goes from `ST_IDLE` to `ST_WR_XFER` on a request with the write function.
- *finish* goes from either transfer state back to `ST_IDLE` after one cycle, unconditionally.

Top module: `tptr_unit`

## Requirements
- R1: After reset the pointer and the latch are zero, the unit is idle, `wr_stb` is 0 and `prog_data` is released (high impedance).
- R2: Mode 00 (hold) uses the current pointer as the table address and leaves the pointer unchanged.
- R3: Mode 01 uses the current pointer as the address, then the pointer becomes pointer+1.
- R4: Mode 10 uses the current pointer as the address, then the pointer becomes pointer−1. The arithmetic wraps modulo 2^21, so 0 steps down to 0x1FFFFF.
- R5: Mode 11 adds 1 to the pointer first and uses the new value as the address. 0x1FFFFF steps up to 0 and addresses word 0.
- R6: A request with function 01 (read) accepted in `ST_IDLE` is followed by exactly one cycle with `tbl_busy`=1 and `prog_addr` = address[20:1]. At the end of that cycle the latch loads the lane picked by address bit 0: 1 selects `prog_data[15:8]` and 0 selects `prog_data[7:0]`.
- R7: A request with function 10 (write) gives one busy cycle on the same address. In that cycle `prog_data` = {latch, latch}, and `wr_stb` is 2'b10 for address bit 0 = 1 or 2'b01 for bit 0 = 0. In every other cycle `wr_stb` is 0 and `prog_data` is released.
- R8: Whenever the unit is not busy, `prog_addr` equals `pc_word`.
- R9: Functions 00 and 11 are no-ops: no busy cycle, no strobe and no pointer change.
- R10: A request presented during a busy cycle is ignored. The pointer steps only once and no second transfer follows.
- R11: `ptr_ld` loads `ptr_ld_val` only while idle. If it coincides with an accepted request, the address comes from the old pointer and the loaded value replaces the stepped one.
- R12: `lat_ld` loads `lat_ld_val` into the latch. In a read transfer cycle the captured memory byte wins over a coinciding latch load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_word | input | 20 | Program counter word address |
| tbl_req | input | 1 | Table operation request |
| tbl_func | input | 2 | 00 no-op, 01 read, 10 write, 11 no-op |
| tbl_mode | input | 2 | Pointer stepping mode |
| ptr_ld | input | 1 | Load pointer strobe |
| ptr_ld_val | input | 21 | Pointer load value |
| lat_ld | input | 1 | Load latch strobe |
| lat_ld_val | input | 8 | Latch load value |
| prog_addr | output | 20 | Program memory word address |
| prog_data | inout | 16 | Shared program data bus |
| wr_stb | output | 2 | Byte-lane write strobe, one-hot |
| tbl_latch | output | 8 | Table latch contents |
| tbl_ptr | output | 21 | Current table pointer |
| tbl_busy | output | 1 | High during the transfer cycle |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a pointer load and the acceptance of a request. The bench raises `ptr_ld` in the same idle cycle as a stepping read. It judges the result by the address seen on `prog_addr` during the transfer, which must come from the old pointer, and by the pointer afterwards, which must equal the loaded value.

The second pair is a latch load and a read capture. The bench raises `lat_ld` in the read transfer cycle and expects the memory byte, not the load value, in the latch.

// File: rtl/tptr_pkg.sv
package tptr_pkg;

    localparam int PTR_W  = 21;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        TF_NOP   = 2'b00,
        TF_READ  = 2'b01,
        TF_WRITE = 2'b10,
        TF_RSVD  = 2'b11
    } tfunc_e;

    typedef enum logic [1:0] {
        SM_HOLD    = 2'b00,
        SM_POSTINC = 2'b01,
        SM_POSTDEC = 2'b10,
        SM_PREINC  = 2'b11
    } step_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_RD_XFER = 2'b01,
        ST_WR_XFER = 2'b10
    } xstate_e;

endpackage

// File: rtl/tptr_step.sv
module tptr_step
    import tptr_pkg::*;
#(
    parameter int AW = PTR_W
) (
    input  logic [AW-1:0] cur_ptr,
    input  logic [1:0]    mode,
    output logic [AW-1:0] tbl_addr,
    output logic [AW-1:0] nxt_ptr
);

    localparam logic [AW-1:0] ONE = AW'(1);

    step_e        step;
    logic [AW-1:0] plus1;
    logic [AW-1:0] minus1;

    assign step   = step_e'(mode);
    assign plus1  = cur_ptr + ONE;
    assign minus1 = cur_ptr - ONE;

    always_comb begin
        tbl_addr = cur_ptr;
        nxt_ptr  = cur_ptr;
        unique case (step)
            SM_HOLD: begin
                tbl_addr = cur_ptr;
                nxt_ptr  = cur_ptr;
            end
            SM_POSTINC: begin
                tbl_addr = cur_ptr;
                nxt_ptr  = plus1;
            end
            SM_POSTDEC: begin
                tbl_addr = cur_ptr;
                nxt_ptr  = minus1;
            end
            SM_PREINC: begin
                tbl_addr = plus1;
                nxt_ptr  = plus1;
            end
        endcase
    end

endmodule

// File: rtl/tptr_ctrl.sv
module tptr_ctrl
    import tptr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic [1:0] func,
    output logic       accept,
    output logic       busy,
    output logic       drive,
    output logic       capture
);

    xstate_e state_q;
    xstate_e state_nx;
    tfunc_e  fn;

    assign fn = tfunc_e'(func);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_nx = state_q;
        accept   = 1'b0;
        busy     = 1'b0;
        drive    = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req && fn == TF_READ) begin
                    accept   = 1'b1;
                    state_nx = ST_RD_XFER;   // take-read
                end else if (req && fn == TF_WRITE) begin
                    accept   = 1'b1;
                    state_nx = ST_WR_XFER;   // take-write
                end
            end
            ST_RD_XFER: begin
                busy     = 1'b1;
                capture  = 1'b1;
                state_nx = ST_IDLE;          // finish
            end
            ST_WR_XFER: begin
                busy     = 1'b1;
                drive    = 1'b1;
                state_nx = ST_IDLE;          // finish
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/tptr_bus.sv
module tptr_bus
    import tptr_pkg::*;
#(
    parameter int AW = PTR_W,
    parameter int BW = BYTE_W
) (
    input  logic                  busy,
    input  logic                  drive,
    input  logic [AW-2:0]         pc_word,
    input  logic [AW-1:0]         addr_q,
    input  logic [BW-1:0]         latch,
    output logic [AW-2:0]         prog_addr,
    inout  wire  [2*BW-1:0]       prog_data,
    output logic [1:0]            wr_stb,
    output logic [BW-1:0]         rd_byte
);

    localparam int LANES = 2;
    localparam int SEL_W = 1;

    logic             lane_sel;
    logic [LANES-1:0] lane_hit;
    logic [BW-1:0]    lane_bytes [LANES];

    assign lane_sel  = addr_q[SEL_W-1:0];
    assign prog_addr = busy ? addr_q[AW-1:SEL_W] : pc_word;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g]               = (lane_sel == SEL_W'(g));
        assign wr_stb[g]                 = drive & lane_hit[g];
        assign prog_data[g*BW +: BW]     = drive ? latch : {BW{1'bz}};
        assign lane_bytes[g]             = prog_data[g*BW +: BW];
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lane_hit[i]) begin
                rd_byte = lane_bytes[i];
            end
        end
    end

endmodule

// File: rtl/tptr_unit.sv
module tptr_unit
    import tptr_pkg::*;
#(
    parameter int AW = PTR_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-2:0] pc_word,
    input  logic          tbl_req,
    input  logic [1:0]    tbl_func,
    input  logic [1:0]    tbl_mode,
    input  logic          ptr_ld,
    input  logic [AW-1:0] ptr_ld_val,
    input  logic          lat_ld,
    input  logic [BW-1:0] lat_ld_val,
    output logic [AW-2:0] prog_addr,
    inout  wire  [2*BW-1:0] prog_data,
    output logic [1:0]    wr_stb,
    output logic [BW-1:0] tbl_latch,
    output logic [AW-1:0] tbl_ptr
    ,output logic         tbl_busy
);

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] addr_q;
    logic [BW-1:0] latch_q;
    logic [AW-1:0] step_addr;
    logic [AW-1:0] step_next;
    logic [BW-1:0] rd_byte;
    logic          accept;
    logic          busy;
    logic          drive;
    logic          capture;

    tptr_step #(.AW(AW)) u_step (
        .cur_ptr  (ptr_q),
        .mode     (tbl_mode),
        .tbl_addr (step_addr),
        .nxt_ptr  (step_next)
    );

    tptr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (tbl_req),
        .func    (tbl_func),
        .accept  (accept),
        .busy    (busy),
        .drive   (drive),
        .capture (capture)
    );

    tptr_bus #(.AW(AW), .BW(BW)) u_bus (
        .busy      (busy),
        .drive     (drive),
        .pc_word   (pc_word),
        .addr_q    (addr_q),
        .latch     (latch_q),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .wr_stb    (wr_stb),
        .rd_byte   (rd_byte)
    );

    // Pointer: an idle load overrides the step of a coinciding request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ptr_ld && !busy) begin
            ptr_q <= ptr_ld_val;
        end else if (accept) begin
            ptr_q <= step_next;
        end
    end

    // Transfer address, frozen for the busy cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= step_addr;
        end
    end

    // Latch: read capture has priority over a direct load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (capture) begin
            latch_q <= rd_byte;
        end else if (lat_ld) begin
            latch_q <= lat_ld_val;
        end
    end

    assign tbl_latch = latch_q;
    assign tbl_ptr   = ptr_q;
    assign tbl_busy  = busy;

endmodule

// File: rtl/tptr_unit_chk.sv
module tptr_unit_chk #(
    parameter int AW = 21,
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-2:0] pc_word,
    input logic          tbl_req,
    input logic [1:0]    tbl_func,
    input logic [1:0]    tbl_mode,
    input logic          ptr_ld,
    input logic [AW-2:0] prog_addr,
    input logic [1:0]    wr_stb,
    input logic [AW-1:0] tbl_ptr,
    input logic          tbl_busy
);

    logic take;
    assign take = !tbl_busy && tbl_req && (tbl_func == 2'b01 || tbl_func == 2'b10) && !ptr_ld;

    // R7
    stb_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb != 2'b00) |-> tbl_busy);

    // R7
    stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_stb));

    // R10
    xfer_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_busy |=> !tbl_busy);

    // R8
    pc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tbl_busy |-> (prog_addr == pc_word));

    // R2
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tbl_mode == 2'b00) |=> (tbl_ptr == $past(tbl_ptr)));

    // R3
    postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tbl_mode == 2'b01) |=> (tbl_ptr == $past(tbl_ptr) + AW'(1)));

    // R4
    postdec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && tbl_mode == 2'b10) |=> (tbl_ptr == $past(tbl_ptr) - AW'(1)));

    // R9
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tbl_busy && tbl_req && (tbl_func == 2'b00 || tbl_func == 2'b11) && !ptr_ld)
        |=> (!tbl_busy && tbl_ptr == $past(tbl_ptr)));

endmodule

bind tptr_unit tptr_unit_chk #(.AW(AW), .BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_word   (pc_word),
    .tbl_req   (tbl_req),
    .tbl_func  (tbl_func),
    .tbl_mode  (tbl_mode),
    .ptr_ld    (ptr_ld),
    .prog_addr (prog_addr),
    .wr_stb    (wr_stb),
    .tbl_ptr   (tbl_ptr),
    .tbl_busy  (tbl_busy)
);

// File: tb/tptr_unit_tb.sv
`timescale 1ns/1ps
module tptr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] pc_word = '0;
    logic        tbl_req = 1'b0;
    logic [1:0]  tbl_func = '0;
    logic [1:0]  tbl_mode = '0;
    logic        ptr_ld = 1'b0;
    logic [20:0] ptr_ld_val = '0;
    logic        lat_ld = 1'b0;
    logic [7:0]  lat_ld_val = '0;
    logic [19:0] prog_addr;
    wire  [15:0] pdata;
    logic [1:0]  wr_stb;
    logic [7:0]  tbl_latch;
    logic [20:0] tbl_ptr;
    logic        tbl_busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [19:0] s_addr;
    logic [1:0]  s_stb;
    logic [15:0] s_data;
    logic        s_busy;

    always #5 clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [19:0] a);
        return {a[7:0] ^ 8'h5A, a[7:0] + 8'h11};
    endfunction

    assign pdata = (tbl_busy && wr_stb == 2'b00) ? mem_word(prog_addr) : 16'hzzzz;

    tptr_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_word    (pc_word),
        .tbl_req    (tbl_req),
        .tbl_func   (tbl_func),
        .tbl_mode   (tbl_mode),
        .ptr_ld     (ptr_ld),
        .ptr_ld_val (ptr_ld_val),
        .lat_ld     (lat_ld),
        .lat_ld_val (lat_ld_val),
        .prog_addr  (prog_addr),
        .prog_data  (pdata),
        .wr_stb     (wr_stb),
        .tbl_latch  (tbl_latch),
        .tbl_ptr    (tbl_ptr),
        .tbl_busy   (tbl_busy)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_ptr(input logic [20:0] v);
        @(negedge clk);
        ptr_ld = 1'b1; ptr_ld_val = v;
        @(negedge clk);
        ptr_ld = 1'b0;
    endtask

    task automatic load_lat(input logic [7:0] v);
        @(negedge clk);
        lat_ld = 1'b1; lat_ld_val = v;
        @(negedge clk);
        lat_ld = 1'b0;
    endtask

    // One table operation; optional pointer load with the request and latch load in the transfer cycle
    task automatic xfer(input logic [1:0] f, input logic [1:0] m,
                        input logic pl, input logic [20:0] pv,
                        input logic ll, input logic [7:0] lv);
        @(negedge clk);
        tbl_req = 1'b1; tbl_func = f; tbl_mode = m;
        ptr_ld = pl; ptr_ld_val = pv;
        @(negedge clk);
        s_addr = prog_addr; s_stb = wr_stb; s_data = pdata; s_busy = tbl_busy;
        tbl_req = 1'b0; tbl_func = 2'b00; ptr_ld = 1'b0;
        lat_ld = ll; lat_ld_val = lv;
        @(negedge clk);
        lat_ld = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ptr", 32'(tbl_ptr), 32'h0);
        check("R1 latch", 32'(tbl_latch), 32'h0);
        check("R1 busy", 32'(tbl_busy), 32'h0);
        check("R1 stb", 32'(wr_stb), 32'h0);
        check("R1 bus", {16'h0, pdata}, {16'h0, 16'hzzzz});
    endtask

    task automatic t_pc_follow;
        pc_word = 20'hABCDE;
        @(negedge clk);
        check("R8 pc a", 32'(prog_addr), 32'hABCDE);
        pc_word = 20'h00042;
        @(negedge clk);
        check("R8 pc b", 32'(prog_addr), 32'h00042);
    endtask

    task automatic t_hold_read;
        load_ptr(21'h00123);
        xfer(2'b01, 2'b00, 1'b0, '0, 1'b0, '0);
        check("R6 busy", 32'(s_busy), 32'h1);
        check("R2 addr", 32'(s_addr), 32'h00091);
        check("R6 hi lane", 32'(tbl_latch), 32'hCB);
        check("R2 ptr", 32'(tbl_ptr), 32'h00123);
        check("R8 after xfer", 32'(prog_addr), 32'(pc_word));
    endtask

    task automatic t_postinc_read;
        load_ptr(21'h00124);
        xfer(2'b01, 2'b01, 1'b0, '0, 1'b0, '0);
        check("R3 addr", 32'(s_addr), 32'h00092);
        check("R6 lo lane", 32'(tbl_latch), 32'hA3);
        check("R3 ptr", 32'(tbl_ptr), 32'h00125);
    endtask

    task automatic t_postdec_wrap;
        load_ptr(21'h0);
        xfer(2'b01, 2'b10, 1'b0, '0, 1'b0, '0);
        check("R4 addr", 32'(s_addr), 32'h0);
        check("R4 latch", 32'(tbl_latch), 32'h11);
        check("R4 ptr wrap", 32'(tbl_ptr), 32'h1FFFFF);
    endtask

    task automatic t_preinc_write;
        load_lat(8'hC3);
        load_ptr(21'h1FFFFF);
        xfer(2'b10, 2'b11, 1'b0, '0, 1'b0, '0);
        check("R5 addr", 32'(s_addr), 32'h0);
        check("R5 ptr wrap", 32'(tbl_ptr), 32'h0);
        check("R7 stb lo", 32'(s_stb), 32'h1);
        check("R7 data", 32'(s_data), 32'hC3C3);
        check("R7 released", {16'h0, pdata}, {16'h0, 16'hzzzz});
        check("R7 stb idle", 32'(wr_stb), 32'h0);
    endtask

    task automatic t_hold_write_odd;
        load_lat(8'h3C);
        load_ptr(21'h00777);
        xfer(2'b10, 2'b00, 1'b0, '0, 1'b0, '0);
        check("R7 odd addr", 32'(s_addr), 32'h003BB);
        check("R7 stb hi", 32'(s_stb), 32'h2);
        check("R7 odd data", 32'(s_data), 32'h3C3C);
        check("R7 latch kept", 32'(tbl_latch), 32'h3C);
    endtask

    task automatic t_nops;
        load_ptr(21'h00333);
        xfer(2'b00, 2'b01, 1'b0, '0, 1'b0, '0);
        check("R9 nop busy", 32'(s_busy), 32'h0);
        check("R9 nop stb", 32'(s_stb), 32'h0);
        check("R9 nop ptr", 32'(tbl_ptr), 32'h00333);
        xfer(2'b11, 2'b11, 1'b0, '0, 1'b0, '0);
        check("R9 rsvd busy", 32'(s_busy), 32'h0);
        check("R9 rsvd ptr", 32'(tbl_ptr), 32'h00333);
    endtask

    task automatic t_busy_ignore;
        load_ptr(21'h00200);
        @(negedge clk);
        tbl_req = 1'b1; tbl_func = 2'b01; tbl_mode = 2'b01;
        @(negedge clk);
        check("R10 busy", 32'(tbl_busy), 32'h1);
        tbl_func = 2'b10; tbl_mode = 2'b11;   // request while busy
        @(negedge clk);
        check("R10 no stb", 32'(wr_stb), 32'h0);
        check("R10 idle", 32'(tbl_busy), 32'h0);
        check("R10 one step", 32'(tbl_ptr), 32'h00201);
        tbl_req = 1'b0; tbl_func = 2'b00; tbl_mode = 2'b00;
        @(negedge clk);
        check("R10 no second", 32'(tbl_ptr), 32'h00201);
    endtask

    task automatic t_ptr_collide;
        load_ptr(21'h00010);
        xfer(2'b01, 2'b01, 1'b1, 21'h00500, 1'b0, '0);
        check("R11 old addr", 32'(s_addr), 32'h00008);
        check("R11 load wins", 32'(tbl_ptr), 32'h00500);
        check("R11 data", 32'(tbl_latch), 32'h19);
    endtask

    task automatic t_lat_collide;
        load_ptr(21'h00041);
        xfer(2'b01, 2'b00, 1'b0, '0, 1'b1, 8'hEE);
        check("R12 capture wins", 32'(tbl_latch), 32'h7A);
        load_lat(8'hEE);
        check("R12 idle load", 32'(tbl_latch), 32'hEE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pc_follow();
        t_hold_read();
        t_postinc_read();
        t_postdec_wrap();
        t_preinc_write();
        t_hold_write_odd();
        t_nops();
        t_busy_ignore();
        t_ptr_collide();
        t_lat_collide();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule